// File: doc/BRIEF.md
# OSD Pixel Attribute and Flash Mixer

This block is the last stage of an on-screen display pixel pipeline. For each pixel clock it receives the glyph bit of the current pixel, the glyph bits directly above and to the left, and the attribute fields of the character that owns the pixel. From these it produces the registered R, G, B and fast-blank outputs that drive the video overlay switch.

The block applies a 3-bit foreground color. It also applies a background that is a solid color, transparent, or a black shadow in the vertical and/or horizontal direction. Per-character flashing follows one of four coded duty modes, timed by a frame counter advanced on vertical sync ticks. A global enable blanks everything. A fast-blank policy bit either forces the overlay switch on over the whole frame or asserts it only where the OSD draws something. A strip-active flag and a per-strip display enable mark where characters may appear.

Top module: `osd_pixel_mixer`

## Requirements
- R1: While rst_ni is low, r_o, g_o, b_o and fblk_o are 0 and the flash timer is at phase 0, frame 0.
- R2: When osd_en_i is 0, r_o, g_o, b_o and fblk_o are all 0.
- R3: Outside a strip (strip_act_i = 0), R, G and B are 0 and fblk_o equals fblk_all_i.
- R4: Inside a strip whose disp_en_i is 0, R, G and B are 0 and fblk_o equals fblk_all_i.
- R5: A drawn glyph pixel (pix_i = 1, character visible) outputs {r,g,b} = fg_i with fg_i[2] = red, fg_i[1] = green, fg_i[0] = blue, and fblk_o = 1.
- R6: An undrawn pixel with bg_i[3] = 0 outputs {r,g,b} = bg_i[2:0] in the same bit order, and fblk_o = 1.
- R7: With bg_i[3] = 1 and pix_i = 0, the pixel is a shadow (RGB 0, fblk_o = 1) when (bg_i[2] and pix_up_i) or (bg_i[1] and pix_left_i). Otherwise it is transparent: RGB 0 and fblk_o = fblk_all_i.
- R8: flash_mode_i = 2'b00 ignores flash_i; the character is always visible.
- R9: The flash timer counts vsync_tick_i pulses; each of 4 phases lasts 16 ticks, and the phase wraps from 3 to 0.
- R10: With flash_i = 1, mode 2'b01 shows the character in phases 0 and 1, mode 2'b10 only in phase 0, and mode 2'b11 in phases 0 to 2. A hidden character is resolved as if pix_i, pix_up_i and pix_left_i were all 0.
- R11: Outputs are registered: they reflect the inputs and flash phase present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vsync_tick_i | input | 1 | One-cycle pulse per frame, advances flash timer |
| osd_en_i | input | 1 | Global OSD enable |
| fblk_all_i | input | 1 | Fast-blank forced over whole frame when 1 |
| flash_mode_i | input | 2 | Flash duty mode code |
| strip_act_i | input | 1 | Pixel lies within a character strip |
| disp_en_i | input | 1 | Display enable of the current strip |
| pix_i | input | 1 | Glyph bit of current pixel |
| pix_up_i | input | 1 | Glyph bit of the pixel above |
| pix_left_i | input | 1 | Glyph bit of the pixel to the left |
| fg_i | input | 3 | Foreground RGB |
| bg_i | input | 4 | Background code: color or shadow/transparent |
| flash_i | input | 1 | Character flash attribute |
| r_o | output | 1 | Red output |
| g_o | output | 1 | Green output |
| b_o | output | 1 | Blue output |
| fblk_o | output | 1 | Fast-blank output |

## Verification
The flash gate and the shadow resolver meet in the same cycle when a flashing character in shadow mode has glyph neighbours set while its phase hides it. The hidden glyph must then suppress its shadow as well, leaving the pixel transparent. The bench provokes this by holding each flash mode across several full 64-tick timer cycles with random glyph bits, shadow codes and flash attributes. A behavioural frame-counting model decides visibility and the shadow/transparent outcome and is compared against all four outputs on every clock.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;
  typedef enum logic [1:0] {
    FL_OFF  = 2'b00,
    FL_HALF = 2'b01,
    FL_1_3  = 2'b10,
    FL_3_1  = 2'b11
  } flash_mode_e;

  typedef struct packed {
    logic r;
    logic g;
    logic b;
    logic fb;
  } osd_px_t;

  localparam int unsigned FLASH_PHASES = 4;
endpackage

// File: rtl/osd_flash_timer.sv
module osd_flash_timer
  import osd_mix_pkg::*;
#(
  parameter int unsigned FRAMES_PER_PHASE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  output logic [1:0] phase_o
);
  localparam int unsigned CNT_W = (FRAMES_PER_PHASE > 1) ? $clog2(FRAMES_PER_PHASE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAMES_PER_PHASE - 1);

  logic [CNT_W-1:0] frm_q;
  logic [1:0]       phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q   <= '0;
      phase_q <= '0;
    end else if (tick_i) begin
      if (frm_q == CNT_LAST) begin
        frm_q   <= '0;
        phase_q <= phase_q + 2'd1;
      end else begin
        frm_q <= frm_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;

  assert_phase_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frm_q == CNT_LAST) |=> (phase_q == $past(phase_q) + 2'd1) && (frm_q == '0));
  assert_phase_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q) && $stable(frm_q));
endmodule

// File: rtl/osd_px_resolve.sv
module osd_px_resolve
  import osd_mix_pkg::*;
(
  input  logic       osd_en_i,
  input  logic       fblk_all_i,
  input  logic       region_i,
  input  logic       hide_i,
  input  logic       pix_i,
  input  logic       pix_up_i,
  input  logic       pix_left_i,
  input  logic [2:0] fg_i,
  input  logic [3:0] bg_i,
  output osd_px_t    px_o
);
  logic on_c, up_c, left_c, shadow_c;

  // hidden flashing glyph drops its own bit and any shadow it casts
  assign on_c     = pix_i      & ~hide_i;
  assign up_c     = pix_up_i   & ~hide_i;
  assign left_c   = pix_left_i & ~hide_i;
  assign shadow_c = (bg_i[2] & up_c) | (bg_i[1] & left_c);

  always_comb begin
    px_o = '{r: 1'b0, g: 1'b0, b: 1'b0, fb: fblk_all_i};
    if (!osd_en_i) begin
      px_o.fb = 1'b0;
    end else if (region_i) begin
      if (on_c) begin
        px_o = '{r: fg_i[2], g: fg_i[1], b: fg_i[0], fb: 1'b1};
      end else if (!bg_i[3]) begin
        px_o = '{r: bg_i[2], g: bg_i[1], b: bg_i[0], fb: 1'b1};
      end else if (shadow_c) begin
        px_o.fb = 1'b1;
      end
    end
  end
endmodule

// File: rtl/osd_pixel_mixer.sv
module osd_pixel_mixer
  import osd_mix_pkg::*;
#(
  parameter int unsigned FRAMES_PER_PHASE = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vsync_tick_i,
  input  logic       osd_en_i,
  input  logic       fblk_all_i,
  input  logic [1:0] flash_mode_i,
  input  logic       strip_act_i,
  input  logic       disp_en_i,
  input  logic       pix_i,
  input  logic       pix_up_i,
  input  logic       pix_left_i,
  input  logic [2:0] fg_i,
  input  logic [3:0] bg_i,
  input  logic       flash_i,
  output logic       r_o,
  output logic       g_o,
  output logic       b_o,
  output logic       fblk_o
);
  logic [1:0]  phase;
  logic        show_c, hide_c, region_c;
  osd_px_t     px_c, px_q;
  flash_mode_e mode_c;

  osd_flash_timer #(.FRAMES_PER_PHASE(FRAMES_PER_PHASE)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (vsync_tick_i),
    .phase_o (phase)
  );

  assign mode_c = flash_mode_e'(flash_mode_i);

  always_comb begin
    unique case (mode_c)
      FL_HALF: show_c = (phase < 2'd2);
      FL_1_3:  show_c = (phase == 2'd0);
      FL_3_1:  show_c = (phase != 2'd3);
      default: show_c = 1'b1;
    endcase
  end

  assign hide_c   = flash_i & ~show_c;
  assign region_c = strip_act_i & disp_en_i;

  osd_px_resolve u_resolve (
    .osd_en_i   (osd_en_i),
    .fblk_all_i (fblk_all_i),
    .region_i   (region_c),
    .hide_i     (hide_c),
    .pix_i      (pix_i),
    .pix_up_i   (pix_up_i),
    .pix_left_i (pix_left_i),
    .fg_i       (fg_i),
    .bg_i       (bg_i),
    .px_o       (px_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) px_q <= '0;
    else         px_q <= px_c;
  end

  assign r_o    = px_q.r;
  assign g_o    = px_q.g;
  assign b_o    = px_q.b;
  assign fblk_o = px_q.fb;

  assert_reset_dark_R1: assert property (@(posedge clk_i)
    !rst_ni |-> {r_o, g_o, b_o, fblk_o} == 4'b0);
  assert_off_dark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osd_en_i |=> {r_o, g_o, b_o, fblk_o} == 4'b0);
  assert_no_strip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osd_en_i && !(strip_act_i && disp_en_i)) |=>
      ({r_o, g_o, b_o} == 3'b0) && (fblk_o == $past(fblk_all_i)));
  assert_fg_color_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osd_en_i && strip_act_i && disp_en_i && pix_i && !flash_i) |=>
      ({r_o, g_o, b_o} == $past(fg_i)) && fblk_o);
  assert_bg_color_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osd_en_i && strip_act_i && disp_en_i && !pix_i && !bg_i[3]) |=>
      ({r_o, g_o, b_o} == $past(bg_i[2:0])) && fblk_o);
  assert_mode_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_mode_i == 2'b00) |-> !hide_c);
endmodule

// File: tb/osd_pixel_mixer_bench.sv
module osd_pixel_mixer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vs = 1'b0, en = 1'b0, fall = 1'b0, strip = 1'b0, de = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       pix = 1'b0, up = 1'b0, left = 1'b0, fl = 1'b0;
  logic [2:0] fg = 3'd0;
  logic [3:0] bg = 4'd0;
  logic       r, g, b, fb;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  osd_pixel_mixer u_osd_pixel_mixer (
    .clk_i(clk), .rst_ni(rst_n), .vsync_tick_i(vs), .osd_en_i(en),
    .fblk_all_i(fall), .flash_mode_i(mode), .strip_act_i(strip),
    .disp_en_i(de), .pix_i(pix), .pix_up_i(up), .pix_left_i(left),
    .fg_i(fg), .bg_i(bg), .flash_i(fl),
    .r_o(r), .g_o(g), .b_o(b), .fblk_o(fb)
  );

  // reference model: frame count integer, outputs one edge late (R11)
  int    frames = 0;
  logic [3:0] exp_q = 4'd0;
  string tag_q = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frames = 0;
      exp_q  = 4'd0;
      tag_q  = "R1";
    end else begin
      int  ph;
      bit  vis, p, pu, pl;
      ph = (frames / 16) % 4;  // R9: 16 ticks per phase, 4 phases
      case (mode)
        2'b01:   vis = (ph == 0 || ph == 1);
        2'b10:   vis = (ph == 0);
        2'b11:   vis = (ph != 3);
        default: vis = 1'b1;
      endcase
      if (!fl) vis = 1'b1;
      p = pix && vis; pu = up && vis; pl = left && vis;
      if (!en) begin
        exp_q = 4'b0000; tag_q = "R2";
      end else if (!strip) begin
        exp_q = {3'b000, fall}; tag_q = "R3";
      end else if (!de) begin
        exp_q = {3'b000, fall}; tag_q = "R4";
      end else begin
        if (p) begin
          exp_q = {fg, 1'b1}; tag_q = "R5";
        end else if (!bg[3]) begin
          exp_q = {bg[2:0], 1'b1}; tag_q = "R6";
        end else if ((bg[2] && pu) || (bg[1] && pl)) begin
          exp_q = 4'b0001; tag_q = "R7";
        end else begin
          exp_q = {3'b000, fall}; tag_q = "R7";
        end
        if (fl && !vis) tag_q = {tag_q, "/R10"};
        else if (fl && mode == 2'b00) tag_q = {tag_q, "/R8"};
      end
      if (vs) frames = frames + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if ({r, g, b, fb} !== exp_q) begin
        n_bad++;
        $display("FAIL %s (R11 timing) got rgbf=%b expected %b at %0t",
                 tag_q, {r, g, b, fb}, exp_q, $time);
      end
    end
  end

  task automatic rand_pixel(input int en_pct, input int cyc);
    vs    = (cyc % 3) == 0;
    en    = ($urandom_range(99) < en_pct);
    fall  = $urandom_range(1);
    strip = ($urandom_range(99) < 85);
    de    = ($urandom_range(99) < 85);
    pix   = $urandom_range(1);
    up    = $urandom_range(1);
    left  = $urandom_range(1);
    fl    = ($urandom_range(99) < 60);
    fg    = 3'($urandom_range(7));
    bg    = ($urandom_range(99) < 65) ? {1'b1, 3'($urandom_range(7))} : 4'($urandom_range(7));
  endtask

  initial begin
    // R1: reset state observed over a few cycles
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 / R10: each mode held across two full 64-tick timer cycles
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int c = 0; c < 400; c++) begin
        @(negedge clk);
        rand_pixel(92, c);
      end
    end
    // R2: mostly disabled overlay, mode 11
    mode = 2'b11;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      rand_pixel(30, c);
    end
    // R7 / R10: hidden flashing glyph casting shadow
    mode = 2'b10;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      rand_pixel(100, c);
      strip = 1'b1; de = 1'b1; fl = 1'b1; pix = 1'b0;
      bg = {1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)), 1'b0};
    end
    // R1: reset mid-run returns outputs to 0 and timer to phase 0
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mode = 2'b01;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      rand_pixel(95, c);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule